// File: doc/BRIEF.md
# Split or Shared 64-bit Peripheral Bus Lane Controller

This block sits between a bus master's transfer logic and the 64 data pads and 8 active-low byte-enable pads of a peripheral bus. It produces the pad output data and output enables, captures the pad inputs, and hands received data and byte enables back to the master. A static layout input, sampled only while reset is held, picks one of two ways to use the pads. In the wide layout, all 64 lanes form one bus that turns around between writes and reads. In the split layout, the upper 32 lanes always transmit and the lower 32 lanes always receive.

In the wide layout, a read request first leaves one cycle with no driver on the bus. The slave then drives for one cycle, and the block samples at the end of that cycle. A second master may take over the bus in the wide layout. While it does, the block drives nothing. In the split layout, no slave drives the receive half while the bus is idle. The block therefore parks that half at zero during reset and after a set number of idle cycles, and releases it in the same cycle that a receive cycle begins.

Top module: `lane_split_bus`

## Requirements
- R1: The layout (`mode_wide_i`: 1 = wide, 0 = split) is taken only while `rst_ni` is low. A change of `mode_wide_i` outside reset leaves the lane drive pattern unchanged until the next reset.
- R2: Wide layout, write: `wr_i` high in cycle c makes cycle c+1 drive all 64 data enables and all 8 byte-enable enables high, with `pad_dat_o` = `wr_dat_i` and `pad_be_o` = `wr_be_ni`. In a wide cycle with no accepted write, every enable is low.
- R3: Wide layout, read: `rd_i` high in cycle c leaves every data and byte-enable enable low in cycles c+1 and c+2. The pads are sampled at the end of c+2. `rd_valid_o` is high in c+3, with `rd_dat_o` = all 64 sampled bits and `rd_be_no` = all 8 sampled byte enables.
- R4: Wide layout: a write requested in the same cycle as `rd_i`, or in the cycle after it, is dropped, and nothing is driven in the following cycle. A write two cycles after `rd_i` is accepted.
- R5: Split layout: data enables 63:32 and byte-enable enables 7:4 are high in every cycle, reset included. `wr_i` in cycle c puts `wr_dat_i[63:32]` on `pad_dat_o[63:32]` and `wr_be_ni[7:4]` on `pad_be_o[7:4]` in c+1. Without a write, `pad_be_o[7:4]` is 4'hF and the transmit data holds.
- R6: Split layout: byte-enable enables 3:0 are never high. `rd_i` in cycle c samples `pad_dat_i[31:0]` and `pad_be_i[3:0]` at the end of c, giving `rd_valid_o` high in c+1 with `rd_dat_o` = {32'h0, data} and `rd_be_no` = {4'hF, enables}.
- R7: Split layout: during reset, and after reset until the first receive cycle, the receive half is parked: data enables 31:0 are high and `pad_dat_o[31:0]` is zero.
- R8: Split layout: parking is released in the same cycle that `rd_i` is high. After a last receive cycle c, the receive half stays undriven for `IDLE_CYCLES` cycles and is parked again from cycle c+`IDLE_CYCLES`+1.
- R9: In the wide layout, `share_i` high forces every data and byte-enable enable low in that same cycle. In the split layout, `share_i` has no effect.
- R10: During reset in the wide layout, no enable is high and `rd_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset; the layout is taken while low |
| mode_wide_i | input | 1 | Layout select: 1 wide, 0 split |
| share_i | input | 1 | Second master owns the bus (wide layout only) |
| wr_i | input | 1 | Write / transmit request |
| wr_dat_i | input | DATA_W | Write data; split layout uses the upper half |
| wr_be_ni | input | DATA_W/8 | Write byte enables, active low |
| rd_i | input | 1 | Wide: read request; split: receive cycle in progress |
| rd_dat_o | output | DATA_W | Captured read data |
| rd_be_no | output | DATA_W/8 | Captured byte enables, active low |
| rd_valid_o | output | 1 | Captured data valid for one cycle |
| pad_dat_i | input | DATA_W | Data pad inputs |
| pad_dat_o | output | DATA_W | Data pad outputs |
| pad_dat_oe_o | output | DATA_W | Data pad output enables, per bit |
| pad_be_i | input | DATA_W/8 | Byte-enable pad inputs |
| pad_be_o | output | DATA_W/8 | Byte-enable pad outputs |
| pad_be_oe_o | output | DATA_W/8 | Byte-enable pad output enables |

## Verification
The bench builds the block with the default 64-bit width and sets `IDLE_CYCLES` to 6. This keeps the full count to re-parking short enough to walk cycle by cycle, so the release edge and the re-park edge are both checked exactly. It also exercises a threshold that is not a power of two. Both layouts are brought up through reset inside one run, so the bench can also check that a layout change outside reset is ignored.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int unsigned LANE_W = 8;
  typedef enum logic {LAYOUT_SPLIT = 1'b0, LAYOUT_WIDE = 1'b1} layout_e;
endpackage

// File: rtl/lsb_tx_stage.sv
module lsb_tx_stage #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned BE_W = DATA_W / lsb_pkg::LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_dat_i,
  input  logic [BE_W-1:0]   wr_be_ni,
  input  logic              rd_i,
  input  logic              rd_pend_i,
  output logic [DATA_W-1:0] dat_o,
  output logic [BE_W-1:0]   be_no,
  output logic              drv_o
);
  logic accept;
  // wide layout keeps the turnaround and slave cycles free
  assign accept = wr_i & (~wide_i | ~(rd_i | rd_pend_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_o <= '0;
      be_no <= '1;
      drv_o <= 1'b0;
    end else begin
      if (accept) dat_o <= wr_dat_i;
      be_no <= accept ? wr_be_ni : '1;
      drv_o <= accept & wide_i;
    end
  end
endmodule

// File: rtl/lsb_rx_stage.sv
module lsb_rx_stage #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned BE_W   = DATA_W / lsb_pkg::LANE_W,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned HALF_B = BE_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wide_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] pad_dat_i,
  input  logic [BE_W-1:0]   pad_be_i,
  output logic              pend_o,
  output logic [DATA_W-1:0] rd_dat_o,
  output logic [BE_W-1:0]   rd_be_no,
  output logic              rd_valid_o
);
  logic slave_q, capture;

  // wide: request -> turnaround -> slave cycle; split: sample in the receive cycle
  assign capture = wide_i ? slave_q : rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o     <= 1'b0;
      slave_q    <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_dat_o   <= '0;
      rd_be_no   <= '1;
    end else begin
      pend_o     <= rd_i & wide_i;
      slave_q    <= pend_o;
      rd_valid_o <= capture;
      if (capture) begin
        rd_dat_o <= wide_i ? pad_dat_i : {{HALF_W{1'b0}}, pad_dat_i[HALF_W-1:0]};
        rd_be_no <= wide_i ? pad_be_i  : {{HALF_B{1'b1}}, pad_be_i[HALF_B-1:0]};
      end
    end
  end
endmodule

// File: rtl/lsb_park.sv
module lsb_park #(
  parameter int unsigned IDLE_CYCLES = 16,
  localparam int unsigned CNT_W = $clog2(IDLE_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic park_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYCLES - 1);
  logic [CNT_W-1:0] idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_q <= '0;
      park_o <= 1'b1;
    end else if (rx_i) begin
      idle_q <= '0;
      park_o <= 1'b0;
    end else if (!park_o) begin
      if (idle_q == LAST) park_o <= 1'b1;
      else                idle_q <= idle_q + 1'b1;
    end
  end
endmodule

// File: rtl/lane_split_bus.sv
module lane_split_bus
  import lsb_pkg::*;
#(
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned IDLE_CYCLES = 16,
  localparam int unsigned BE_W   = DATA_W / LANE_W,
  localparam int unsigned HALF_B = BE_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_wide_i,
  input  logic              share_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_dat_i,
  input  logic [BE_W-1:0]   wr_be_ni,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_dat_o,
  output logic [BE_W-1:0]   rd_be_no,
  output logic              rd_valid_o,
  input  logic [DATA_W-1:0] pad_dat_i,
  output logic [DATA_W-1:0] pad_dat_o,
  output logic [DATA_W-1:0] pad_dat_oe_o,
  input  logic [BE_W-1:0]   pad_be_i,
  output logic [BE_W-1:0]   pad_be_o,
  output logic [BE_W-1:0]   pad_be_oe_o
);
  layout_e layout_q;
  logic wide_mode, rd_pend, wide_drv, rx_park, park_q, drv_q;
  logic [DATA_W-1:0] tx_dat;
  logic [BE_W-1:0]   tx_be_n;

  // layout follows the pin only while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) layout_q <= layout_e'(mode_wide_i);
  end

  assign wide_mode = (layout_q == LAYOUT_WIDE);

  lsb_tx_stage #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni, .wide_i(wide_mode), .wr_i, .wr_dat_i, .wr_be_ni,
    .rd_i, .rd_pend_i(rd_pend), .dat_o(tx_dat), .be_no(tx_be_n), .drv_o(drv_q)
  );

  lsb_rx_stage #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .wide_i(wide_mode), .rd_i, .pad_dat_i, .pad_be_i,
    .pend_o(rd_pend), .rd_dat_o, .rd_be_no, .rd_valid_o
  );

  lsb_park #(.IDLE_CYCLES(IDLE_CYCLES)) u_park (
    .clk_i, .rst_ni, .rx_i(rd_i & ~wide_mode), .park_o(park_q)
  );

  assign wide_drv = drv_q & ~share_i;
  assign rx_park  = park_q & ~rd_i;

  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    if (g >= HALF_B) begin : g_tx_half
      assign pad_dat_oe_o[g*LANE_W +: LANE_W] = {LANE_W{wide_mode ? wide_drv : 1'b1}};
      assign pad_dat_o[g*LANE_W +: LANE_W]    = tx_dat[g*LANE_W +: LANE_W];
      assign pad_be_oe_o[g]                   = wide_mode ? wide_drv : 1'b1;
      assign pad_be_o[g]                      = tx_be_n[g];
    end else begin : g_rx_half
      assign pad_dat_oe_o[g*LANE_W +: LANE_W] = {LANE_W{wide_mode ? wide_drv : rx_park}};
      assign pad_dat_o[g*LANE_W +: LANE_W]    = wide_mode ? tx_dat[g*LANE_W +: LANE_W] : '0;
      assign pad_be_oe_o[g]                   = wide_mode & wide_drv;
      assign pad_be_o[g]                      = wide_mode ? tx_be_n[g] : 1'b1;
    end
  end
endmodule

// File: rtl/lane_split_bus_chk.sv
module lane_split_bus_chk #(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned BE_W   = DATA_W / 8,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned HALF_B = BE_W / 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wide_i,
  input logic              share_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] pad_dat_oe_i,
  input logic [BE_W-1:0]   pad_be_oe_i
);
  a_r1_layout_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(wide_i));

  a_r2_wide_oe_uniform: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_i |-> (pad_dat_oe_i == '0 || pad_dat_oe_i == '1));

  a_r3_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_i && rd_i |=> pad_dat_oe_i == '0 && pad_be_oe_i == '0);

  a_r5_tx_always: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |-> (&pad_dat_oe_i[DATA_W-1:HALF_W]) && (&pad_be_oe_i[BE_W-1:HALF_B]));

  a_r6_rx_be_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i |-> pad_be_oe_i[HALF_B-1:0] == '0);

  a_r8_park_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wide_i && rd_i |-> pad_dat_oe_i[HALF_W-1:0] == '0);

  a_r9_share_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wide_i && share_i |-> pad_dat_oe_i == '0 && pad_be_oe_i == '0);
endmodule

bind lane_split_bus lane_split_bus_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .wide_i(wide_mode), .share_i, .rd_i,
  .pad_dat_oe_i(pad_dat_oe_o), .pad_be_oe_i(pad_be_oe_o)
);

// File: tb/lane_split_bus_test.sv
module lane_split_bus_test;
  localparam int unsigned DW = 64;
  localparam int unsigned BW = 8;
  localparam int unsigned IDLE = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0, mode_wide_i = 1'b0, share_i = 1'b0;
  logic wr_i = 1'b0, rd_i = 1'b0;
  logic [DW-1:0] wr_dat_i = '0, pad_dat_i = '0;
  logic [BW-1:0] wr_be_ni = '1, pad_be_i = '1;
  logic [DW-1:0] rd_dat_o, pad_dat_o, pad_dat_oe_o;
  logic [BW-1:0] rd_be_no, pad_be_o, pad_be_oe_o;
  logic rd_valid_o;
  int checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;

  lane_split_bus #(.DATA_W(DW), .IDLE_CYCLES(IDLE)) uut (
    .clk_i, .rst_ni, .mode_wide_i, .share_i, .wr_i, .wr_dat_i, .wr_be_ni, .rd_i,
    .rd_dat_o, .rd_be_no, .rd_valid_o, .pad_dat_i, .pad_dat_o, .pad_dat_oe_o,
    .pad_be_i, .pad_be_o, .pad_be_oe_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic do_reset(input logic wide);
    rst_ni = 1'b0; mode_wide_i = wide; share_i = 0; wr_i = 0; rd_i = 0; wr_be_ni = '1;
    tick(); tick();
    if (wide) begin
      chk("R10 reset data oe", pad_dat_oe_o, '0);
      chk("R10 reset be oe", 64'(pad_be_oe_o), 64'h0);
      chk("R10 reset valid", 64'(rd_valid_o), 64'h0);
    end else begin
      chk("R5 R7 reset data oe", pad_dat_oe_o, '1);
      chk("R7 reset park zero", 64'(pad_dat_o[31:0]), 64'h0);
      chk("R5 R6 reset be oe", 64'(pad_be_oe_o), 64'hF0);
    end
    tick();
    rst_ni = 1'b1;
    tick();
  endtask

  task automatic t_split_tx();
    wr_i = 1; wr_dat_i = 64'hDEAD_BEEF_0123_4567; wr_be_ni = 8'h3C;
    tick();
    wr_i = 0; wr_be_ni = '1; wr_dat_i = '0;
    chk("R7 parked after reset", 64'(pad_dat_oe_o[31:0]), 64'hFFFF_FFFF);
    chk("R5 tx data", 64'(pad_dat_o[63:32]), 64'hDEAD_BEEF);
    chk("R5 tx be", 64'(pad_be_o[7:4]), 64'h3);
    tick();
    chk("R5 tx be idle", 64'(pad_be_o[7:4]), 64'hF);
    chk("R5 tx data holds", 64'(pad_dat_o[63:32]), 64'hDEAD_BEEF);
    chk("R5 tx oe", 64'(pad_dat_oe_o[63:32]), 64'hFFFF_FFFF);
  endtask

  task automatic t_split_rx();
    rd_i = 1; pad_dat_i = 64'h1111_2222_3333_4444; pad_be_i = 8'hA5;
    #1;
    chk("R8 release same cycle", 64'(pad_dat_oe_o[31:0]), 64'h0);
    chk("R6 rx be oe", 64'(pad_be_oe_o[3:0]), 64'h0);
    tick();
    rd_i = 0; pad_dat_i = 64'h9999_9999_9999_9999; pad_be_i = 8'h00;
    chk("R6 rx valid", 64'(rd_valid_o), 64'h1);
    chk("R6 rx data", rd_dat_o, 64'h0000_0000_3333_4444);
    chk("R6 rx be", 64'(rd_be_no), 64'hF5);
    for (int i = 0; i < IDLE; i++) begin
      chk($sformatf("R8 idle cycle %0d undriven", i + 1), 64'(pad_dat_oe_o[31:0]), 64'h0);
      tick();
    end
    chk("R8 re-parked", 64'(pad_dat_oe_o[31:0]), 64'hFFFF_FFFF);
    chk("R8 park value", 64'(pad_dat_o[31:0]), 64'h0);
    chk("R6 single valid", 64'(rd_valid_o), 64'h0);
  endtask

  task automatic t_split_share_mode();
    share_i = 1; #1;
    chk("R9 share ignored split", pad_dat_oe_o, '1);
    share_i = 0; mode_wide_i = 1;
    tick(); tick();
    chk("R1 layout kept split", pad_dat_oe_o, '1);
    chk("R1 be pattern kept", 64'(pad_be_oe_o), 64'hF0);
  endtask

  task automatic t_wide_write();
    wr_i = 1; wr_dat_i = 64'h0F1E_2D3C_4B5A_6978; wr_be_ni = 8'h0F;
    tick();
    wr_i = 0; wr_be_ni = '1;
    chk("R2 write oe", pad_dat_oe_o, '1);
    chk("R2 write data", pad_dat_o, 64'h0F1E_2D3C_4B5A_6978);
    chk("R2 write be oe", 64'(pad_be_oe_o), 64'hFF);
    chk("R2 write be", 64'(pad_be_o), 64'h0F);
    tick();
    chk("R2 idle no drive", pad_dat_oe_o, '0);
  endtask

  task automatic t_wide_read();
    rd_i = 1; pad_dat_i = 64'hAAAA_AAAA_AAAA_AAAA;
    tick();
    rd_i = 0;
    chk("R3 turnaround oe", pad_dat_oe_o, '0);
    chk("R3 no early valid", 64'(rd_valid_o), 64'h0);
    tick();
    chk("R3 slave cycle oe", pad_dat_oe_o, '0);
    chk("R3 slave cycle be oe", 64'(pad_be_oe_o), 64'h0);
    pad_dat_i = 64'h8765_4321_FEDC_BA98; pad_be_i = 8'h81;
    tick();
    pad_dat_i = 64'h5555_5555_5555_5555; pad_be_i = 8'hFF;
    chk("R3 valid", 64'(rd_valid_o), 64'h1);
    chk("R3 data", rd_dat_o, 64'h8765_4321_FEDC_BA98);
    chk("R3 be", 64'(rd_be_no), 64'h81);
  endtask

  task automatic t_wide_turn();
    rd_i = 1; wr_i = 1; wr_dat_i = 64'h1;
    tick();
    rd_i = 0;
    chk("R4 same-cycle write dropped", pad_dat_oe_o, '0);
    tick();
    chk("R4 next-cycle write dropped", pad_dat_oe_o, '0);
    wr_i = 0;
    tick(); tick(); tick();
    rd_i = 1;
    tick();
    rd_i = 0;
    tick();
    wr_i = 1; wr_dat_i = 64'h2222;
    tick();
    wr_i = 0;
    chk("R4 write after slave cycle driven", pad_dat_oe_o, '1);
    chk("R4 write data", pad_dat_o, 64'h2222);
  endtask

  task automatic t_wide_share_mode();
    wr_i = 1; wr_dat_i = 64'h3333;
    tick();
    wr_i = 0;
    share_i = 1; #1;
    chk("R9 share data oe", pad_dat_oe_o, '0);
    chk("R9 share be oe", 64'(pad_be_oe_o), 64'h0);
    share_i = 0; #1;
    chk("R9 share released", pad_dat_oe_o, '1);
    mode_wide_i = 0;
    tick(); tick();
    chk("R1 layout kept wide", pad_dat_oe_o, '0);
    chk("R1 be oe kept wide", 64'(pad_be_oe_o), 64'h0);
  endtask

  initial begin
    tick();
    do_reset(1'b0);
    t_split_tx();
    t_split_rx();
    t_split_share_mode();
    do_reset(1'b1);
    t_wide_write();
    t_wide_read();
    t_wide_turn();
    t_wide_share_mode();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule